// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access-Right Checks

This block turns a virtual address into a physical address by searching a small set of cached page mappings all at once. Each stored mapping carries a virtual page number, a physical page number, a residency flag and two access-right flags. A lookup compares the requested page number against every stored tag in the same cycle. One clock later it returns either the translated address or a two-bit fault code that the processor's exception logic can act on. The low page-offset bits bypass translation.

Software refills the buffer through a write port after it resolves a miss. A new mapping reuses the slot of a live mapping with the same virtual page. If there is none, it takes the lowest-numbered empty slot. If the buffer is full, a rotating pointer picks the slot to overwrite. A single flush input empties the whole buffer in one cycle, for example on an address-space switch. Reset does the same flush and also clears the pointer.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup whose page number matches a valid, present entry with no access violation returns, one cycle later, the entry's physical page number joined to the unchanged page-offset bits, with fault code 0.
- R2: A lookup whose page number matches no valid entry returns fault code 1 (miss). Any response with a nonzero fault code drives an all-zero physical address.
- R3: A lookup that hits an entry whose present flag is clear returns fault code 2 (page not resident).
- R4: Access type is encoded 0 = load, 1 = store, 2 = fetch, 3 = reserved. A store to an entry marked read-only returns fault code 3 (protection). Loads and fetches to that entry translate normally.
- R5: A load or store to an entry marked execute-only returns fault code 3. A fetch to that entry translates normally.
- R6: A hit with the reserved access type 3 on a present entry returns fault code 3.
- R7: Faults have a fixed priority: miss over not-resident, and not-resident over protection.
- R8: A refill write with no live match goes into the lowest-numbered invalid slot. The new mapping is visible to lookups from the next cycle. A lookup in the same cycle as the write sees the old contents.
- R9: When every slot is valid, a refill write with no live match replaces the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one, modulo the entry count, on each such replacement.
- R10: A refill write whose virtual page matches a valid entry overwrites that entry in place and does not move the rotating pointer, so no two valid entries ever share a page number.
- R11: The flush input clears every valid flag in one cycle and overrides a refill write in the same cycle. Reset clears all valid flags and sets the pointer to 0.
- R12: The response valid output is the request valid input delayed by one cycle. When no response is due, the fault code and the address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| wr_en | input | 1 | Refill write strobe |
| wr_vpn | input | VA_W-PAGE_W | Virtual page number of the new mapping |
| wr_ppn | input | PA_W-PAGE_W | Physical page number of the new mapping |
| wr_present | input | 1 | Page resident flag |
| wr_ro | input | 1 | Read-only flag |
| wr_xo | input | 1 | Execute-only flag |
| inval_all | input | 1 | Flush every mapping |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_paddr | output | PA_W | Translated physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 not resident, 3 protection |

## Verification
Each lookup result appears at the outputs one clock after the request: the search, the rights check and the address assembly all sit ahead of a single output register. A refill or flush changes the stored mappings at that same edge, so its effect shows on the response to a request issued in the following cycle. A request issued in the same cycle as the refill or flush is answered from the old contents. The bench model applies both rules. It computes the expected response from the old contents at each rising edge, then updates its table. It compares all three outputs at the following falling edge, on every cycle, including idle and reset cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_MISS   = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_PROT   = 2'd3
    } fault_e;

endpackage

// File: rtl/tlb_match.sv
// Parallel tag comparison: one comparator per slot, qualified by its valid flag.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlb_victim.sv
// Slot choice for a refill without a live match: lowest empty slot, else the rotating pointer.
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [IDX_W-1:0]   ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               full
);
    always_comb begin
        full   = &valid;
        victim = ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) victim = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_check.sv
// Fault classification for one lookup, in priority order.
module tlb_check
    import tlb_pkg::*;
(
    input  logic       hit,
    input  logic       present,
    input  logic       ro,
    input  logic       xo,
    input  logic [1:0] acc,
    output logic [1:0] fault
);
    acc_e   acc_t;
    fault_e flt;

    always_comb begin
        acc_t = acc_e'(acc);
        if (!hit) begin
            flt = FLT_MISS;
        end else if (!present) begin
            flt = FLT_ABSENT;
        end else begin
            unique case (acc_t)
                ACC_LOAD:  flt = xo ? FLT_PROT : FLT_NONE;
                ACC_STORE: flt = (ro || xo) ? FLT_PROT : FLT_NONE;
                ACC_FETCH: flt = FLT_NONE;
                default:   flt = FLT_PROT;
            endcase
        end
        fault = flt;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PAGE_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_acc,
    input  logic                   wr_en,
    input  logic [VA_W-PAGE_W-1:0] wr_vpn,
    input  logic [PA_W-PAGE_W-1:0] wr_ppn,
    input  logic                   wr_present,
    input  logic                   wr_ro,
    input  logic                   wr_xo,
    input  logic                   inval_all,
    output logic                   rsp_valid,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [1:0]             rsp_fault
);
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PPN_W = PA_W - PAGE_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            present;
        logic [ENTRIES-1:0]            ro;
        logic [ENTRIES-1:0]            xo;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [IDX_W-1:0]              ptr;
        logic                          rv;
        logic [PA_W-1:0]               pa;
        logic [1:0]                    flt;
    } state_t;

    state_t q, d;

    logic [ENTRIES-1:0] lk_hit, wr_hit;
    logic [IDX_W-1:0]   vic_idx, wr_hit_idx, wr_idx;
    logic               vic_full;
    logic [PPN_W-1:0]   sel_ppn;
    logic               sel_p, sel_ro, sel_xo;
    logic [1:0]         lk_fault;

    tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
        .valid (q.valid),
        .tags  (q.vpn),
        .key   (req_vaddr[VA_W-1:PAGE_W]),
        .hit   (lk_hit)
    );

    tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_wr_match (
        .valid (q.valid),
        .tags  (q.vpn),
        .key   (wr_vpn),
        .hit   (wr_hit)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid  (q.valid),
        .ptr    (q.ptr),
        .victim (vic_idx),
        .full   (vic_full)
    );

    // Select fields of the (at most one) hitting slot.
    always_comb begin
        sel_ppn = '0;
        sel_p   = 1'b0;
        sel_ro  = 1'b0;
        sel_xo  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit[i]) begin
                sel_ppn = sel_ppn | q.ppn[i];
                sel_p   = sel_p   | q.present[i];
                sel_ro  = sel_ro  | q.ro[i];
                sel_xo  = sel_xo  | q.xo[i];
            end
        end
    end

    tlb_check u_check (
        .hit     (|lk_hit),
        .present (sel_p),
        .ro      (sel_ro),
        .xo      (sel_xo),
        .acc     (req_acc),
        .fault   (lk_fault)
    );

    always_comb begin
        wr_hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_hit[i]) wr_hit_idx = IDX_W'(i);
        end
        wr_idx = (|wr_hit) ? wr_hit_idx : vic_idx;
    end

    // Next-state computation.
    always_comb begin
        d = q;

        d.rv  = req_valid;
        d.flt = req_valid ? lk_fault : 2'd0;
        d.pa  = (req_valid && (lk_fault == FLT_NONE))
              ? {sel_ppn, req_vaddr[PAGE_W-1:0]} : '0;

        if (inval_all) begin
            d.valid = '0;
        end else if (wr_en) begin
            d.valid[wr_idx]   = 1'b1;
            d.vpn[wr_idx]     = wr_vpn;
            d.ppn[wr_idx]     = wr_ppn;
            d.present[wr_idx] = wr_present;
            d.ro[wr_idx]      = wr_ro;
            d.xo[wr_idx]      = wr_xo;
            if (!(|wr_hit) && vic_full) begin
                d.ptr = (q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rsp_valid = q.rv;
    assign rsp_paddr = q.pa;
    assign rsp_fault = q.flt;

    assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_fault == 2'd0 && rsp_paddr == '0));

    assert_fault_zero_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_fault != 2'd0 ||
                       rsp_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0])));

    assert_miss_first_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(|lk_hit)) |=> (rsp_fault == 2'd1));

    assert_single_match_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit));

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> (q.valid == '0));

    assert_victim_is_free_R8: assert property (@(posedge clk) disable iff (rst)
        !vic_full |-> !q.valid[vic_idx]);

endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int ENT   = 16;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int PG    = 12;
    localparam int VPN_W = VA_W - PG;
    localparam int PPN_W = PA_W - PG;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid;
    logic [VA_W-1:0]  req_vaddr;
    logic [1:0]       req_acc;
    logic             wr_en;
    logic [VPN_W-1:0] wr_vpn;
    logic [PPN_W-1:0] wr_ppn;
    logic             wr_present, wr_ro, wr_xo;
    logic             inval_all;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic [1:0]       rsp_fault;

    tlb_xlate #(.ENTRIES(ENT), .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PG)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_present(wr_present), .wr_ro(wr_ro), .wr_xo(wr_xo),
        .inval_all(inval_all), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference table.
    bit               m_val [ENT];
    logic [VPN_W-1:0] m_vpn [ENT];
    logic [PPN_W-1:0] m_ppn [ENT];
    bit               m_p [ENT], m_ro [ENT], m_xo [ENT];
    int               m_ptr;

    bit               e_v;
    logic [PA_W-1:0]  e_pa;
    logic [1:0]       e_f;
    string            e_tag, cur_tag;
    int               n_chk = 0, n_err = 0;

    function automatic logic [VA_W-1:0] mkva(int vpn, int off);
        return {VPN_W'(vpn), PG'(off)};
    endfunction

    task automatic model_edge();
        int h, w;
        e_tag = cur_tag;
        if (rst) begin
            for (int i = 0; i < ENT; i++) m_val[i] = 0;
            m_ptr = 0; e_v = 0; e_pa = '0; e_f = 2'd0;
            return;
        end
        e_v = req_valid; e_pa = '0; e_f = 2'd0;
        if (req_valid) begin
            h = -1;
            for (int i = 0; i < ENT; i++)
                if (m_val[i] && m_vpn[i] == req_vaddr[VA_W-1:PG]) h = i;
            if (h < 0) e_f = 2'd1;
            else if (!m_p[h]) e_f = 2'd2;
            else if (req_acc == 2'd3) e_f = 2'd3;
            else if (req_acc == 2'd0 && m_xo[h]) e_f = 2'd3;
            else if (req_acc == 2'd1 && (m_ro[h] || m_xo[h])) e_f = 2'd3;
            if (e_f == 2'd0) e_pa = {m_ppn[h], req_vaddr[PG-1:0]};
        end
        if (inval_all) begin
            for (int i = 0; i < ENT; i++) m_val[i] = 0;
        end else if (wr_en) begin
            w = -1;
            for (int i = 0; i < ENT; i++)
                if (m_val[i] && m_vpn[i] == wr_vpn) w = i;
            if (w < 0)
                for (int i = ENT - 1; i >= 0; i--) if (!m_val[i]) w = i;
            if (w < 0) begin
                w = m_ptr;
                m_ptr = (m_ptr + 1) % ENT;
            end
            m_val[w] = 1; m_vpn[w] = wr_vpn; m_ppn[w] = wr_ppn;
            m_p[w] = wr_present; m_ro[w] = wr_ro; m_xo[w] = wr_xo;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== e_v || rsp_fault !== e_f || rsp_paddr !== e_pa) begin
            n_err++;
            $display("FAIL %s: got v=%0b f=%0d pa=%h, expected v=%0b f=%0d pa=%h",
                     e_tag, rsp_valid, rsp_fault, rsp_paddr, e_v, e_f, e_pa);
        end
    endtask

    task automatic idle();
        req_valid = 0; wr_en = 0; inval_all = 0;
    endtask

    task automatic look(int vpn, int off, int acc, string tag);
        idle();
        req_valid = 1; req_vaddr = mkva(vpn, off); req_acc = 2'(acc);
        cur_tag = tag;
        step();
    endtask

    task automatic wr(int vpn, int ppn, bit p, bit ro, bit xo, string tag);
        idle();
        wr_en = 1; wr_vpn = VPN_W'(vpn); wr_ppn = PPN_W'(ppn);
        wr_present = p; wr_ro = ro; wr_xo = xo;
        cur_tag = tag;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1; idle(); req_vaddr = '0; req_acc = '0;
        wr_vpn = '0; wr_ppn = '0; wr_present = 0; wr_ro = 0; wr_xo = 0;
        cur_tag = "R11 reset";
        @(negedge clk);
        repeat (3) step();
        rst = 0;
        idle(); cur_tag = "R12 idle"; step();

        look(5, 'h123, 0, "R2 empty miss");
        wr(5, 'hA5, 1, 0, 0, "R8 fill");
        wr(6, 'hA6, 1, 1, 0, "R8 fill");
        wr(7, 'hA7, 1, 0, 1, "R8 fill");
        wr(8, 'hA8, 0, 1, 0, "R8 fill");
        look(5, 'h123, 0, "R1 load hit");
        look(5, 'hFFF, 1, "R1 store hit");
        look(5, 'h000, 2, "R1 fetch hit");
        look(6, 'h010, 0, "R4 ro load");
        look(6, 'h010, 1, "R4 ro store");
        look(6, 'h010, 2, "R4 ro fetch");
        look(7, 'h020, 0, "R5 xo load");
        look(7, 'h020, 1, "R5 xo store");
        look(7, 'h020, 2, "R5 xo fetch");
        look(8, 'h030, 0, "R3 absent");
        look(8, 'h030, 1, "R7 absent over prot");
        look(99, 'h030, 3, "R7 miss first");
        look(5, 'h040, 3, "R6 reserved type");

        // Same-cycle write and lookup of that page.
        idle();
        wr_en = 1; wr_vpn = 9; wr_ppn = 'hA9; wr_present = 1; wr_ro = 0; wr_xo = 0;
        req_valid = 1; req_vaddr = mkva(9, 'h55); req_acc = 0;
        cur_tag = "R8 old contents"; step();
        look(9, 'h55, 0, "R8 visible next");

        wr(5, 'hB5, 1, 0, 0, "R10 overwrite");
        look(5, 'h321, 0, "R10 new ppn");
        for (int v = 20; v < 31; v++) wr(v, 'h100 + v, 1, 0, 0, "R8 fill rest");
        wr(40, 'hC0, 1, 0, 0, "R9 evict");
        wr(41, 'hC1, 1, 0, 0, "R9 evict");
        look(5, 1, 0, "R9 evicted slot0");
        look(6, 1, 0, "R9 evicted slot1");
        look(7, 1, 2, "R9 kept slot2");
        look(40, 1, 0, "R9 new entry");
        wr(41, 'hD1, 1, 0, 0, "R10 overwrite full");
        wr(42, 'hC2, 1, 0, 0, "R10 pointer held");
        look(7, 1, 2, "R10 slot2 evicted");
        look(41, 2, 0, "R10 in place");
        look(8, 1, 0, "R9 slot3 kept");

        // Flush with a same-cycle write.
        idle();
        inval_all = 1; wr_en = 1; wr_vpn = 50; wr_ppn = 'hE0; wr_present = 1;
        cur_tag = "R11 flush"; step();
        look(50, 0, 0, "R11 write dropped");
        look(40, 0, 0, "R11 flushed");
        wr(60, 'hF0, 1, 0, 0, "R8 after flush");
        look(60, 7, 1, "R8 after flush");

        for (int k = 0; k < 600; k++) begin
            idle();
            cur_tag = "random";
            req_valid = ($urandom % 3) != 0;
            req_vaddr = mkva($urandom % 24, $urandom % 4096);
            req_acc = 2'($urandom % 4);
            wr_en = ($urandom % 3) == 0;
            wr_vpn = VPN_W'($urandom % 24);
            wr_ppn = PPN_W'($urandom);
            wr_present = ($urandom % 4) != 0;
            wr_ro = ($urandom % 3) == 0;
            wr_xo = ($urandom % 4) == 0;
            inval_all = ($urandom % 97) == 0;
            step();
        end

        idle(); cur_tag = "R12 final idle"; step();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule